// File: doc/BRIEF.md
# Stacked Flash Region Address Decoder

This block turns a byte offset into a memory-mapped flash window into a choice of one of four external devices. The four device regions are stacked upward from offset zero in a fixed order (region 0, then 1, 2, 3). Each region carries a programmable size in kilobyte units. A region's start is never programmed: it is the sum of the sizes of all regions below it, so leaving a region at size zero removes it from the map without creating a hole.

A lookup presents an address with a valid strobe. One clock later the block returns a one-hot device select, the offset relative to the start of the chosen region, and that region's read-sequence index, which a sequencer uses to choose the command program for the access. An address at or above the end of the last region returns an out-of-range flag and no select. Size and sequence registers are written through a small configuration port that addresses one region at a time.

Top module: `flash_region_decoder`

## Requirements
- R1: After reset every region size and sequence index is zero, `rsp_valid` is low and all response outputs are zero, so the first lookup after reset reports out-of-range.
- R2: Region i (i = 0..3, the value of `cfg_region` that addresses it) starts at the byte address equal to 1024 times the sum of the sizes of regions 0..i-1 and ends just below its start plus 1024 times its own size.
- R3: For an address inside a region, `rsp_sel` has exactly one bit set, bit i for region i, and `rsp_oor` is low.
- R4: `rsp_offset` equals the lookup address minus the start of the selected region.
- R5: An address at or above 1024 times the sum of all four sizes sets `rsp_oor`, with `rsp_sel`, `rsp_offset` and `rsp_seq` all zero.
- R6: A region of size zero is never selected; with only region 2 non-zero, every address below its end selects bit 2 (`rsp_sel` = 4'b0100) with offset equal to the address.
- R7: `rsp_seq` equals the sequence index last written to the selected region.
- R8: The response to a lookup presented at a rising edge appears after that edge with `rsp_valid` high for one cycle; in a cycle with no lookup `rsp_valid` is low and the other response outputs keep their values.
- R9: A size written at a clock edge is used by a lookup presented at the next edge; a lookup presented at the same edge as the write uses the old size.
- R10: `size_we` changes only the size of the region named by `cfg_region`, and `seq_we` changes only that region's sequence index; the other register of the pair is left as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_we | input | 1 | Write `cfg_size` into the addressed region's size |
| seq_we | input | 1 | Write `cfg_seq` into the addressed region's sequence index |
| cfg_region | input | 2 | Region addressed by a configuration write |
| cfg_size | input | 20 | Region size in kilobytes |
| cfg_seq | input | 5 | Region read-sequence index |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Byte offset to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_sel | output | 4 | One-hot device select |
| rsp_offset | output | 32 | Offset inside the selected region |
| rsp_seq | output | 5 | Sequence index of the selected region |
| rsp_oor | output | 1 | Address beyond the last region |

## Verification
A corrupted size register or a broken prefix sum moves every boundary above the faulty region, so the very next lookup near such a boundary returns the wrong select or an offset shifted by a multiple of 1024, one cycle after it is issued. A wrong sequence register shows up only when its region is selected, so the stimulus walks every region and both sides of each boundary, including zero-size regions whose start and end coincide. Configuration ordering is observed by issuing lookups in the same cycle as a write and in the cycle just after it.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

  // Region sizes are held in kilobytes; byte bounds shift left by this.
  localparam int KB_SHIFT = 10;

  // Index width that stays at least one bit wide.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/region_cfg_regs.sv
module region_cfg_regs #(
  parameter int N_REGIONS = 4,
  parameter int SIZE_W    = 20,
  parameter int SEQ_W     = 5,
  parameter int RIDX_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               size_we,
  input  logic                               seq_we,
  input  logic [RIDX_W-1:0]                  cfg_region,
  input  logic [SIZE_W-1:0]                  cfg_size,
  input  logic [SEQ_W-1:0]                   cfg_seq,
  output logic [N_REGIONS-1:0][SIZE_W-1:0]   size_q,
  output logic [N_REGIONS-1:0][SEQ_W-1:0]    seq_q
);

  for (genvar i = 0; i < N_REGIONS; i++) begin : g_reg
    logic hit;
    assign hit = (cfg_region == RIDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        size_q[i] <= '0;
      end else if (size_we && hit) begin
        size_q[i] <= cfg_size;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        seq_q[i] <= '0;
      end else if (seq_we && hit) begin
        seq_q[i] <= cfg_seq;
      end
    end
  end

endmodule

// File: rtl/region_bounds.sv
module region_bounds
  import flash_map_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int SIZE_W    = 20,
  parameter int BOUND_W   = 32
) (
  input  logic [N_REGIONS-1:0][SIZE_W-1:0]  size_q,
  output logic [N_REGIONS-1:0][BOUND_W-1:0] base,
  output logic [N_REGIONS-1:0][BOUND_W-1:0] limit
);

  // Running sum of region sizes: each start is the end of the one below.
  for (genvar i = 0; i < N_REGIONS; i++) begin : g_sum
    logic [BOUND_W-1:0] span;
    assign span = BOUND_W'(size_q[i]) << KB_SHIFT;

    if (i == 0) begin : g_first
      assign base[i] = '0;
    end else begin : g_next
      assign base[i] = limit[i-1];
    end

    assign limit[i] = base[i] + span;
  end

endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W    = 32,
  parameter int BOUND_W   = 32,
  parameter int CMP_W     = 32
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [N_REGIONS-1:0][BOUND_W-1:0] base,
  input  logic [N_REGIONS-1:0][BOUND_W-1:0] limit,
  output logic [N_REGIONS-1:0]              hit,
  output logic                              beyond
);

  logic [CMP_W-1:0] a_ext;
  assign a_ext = CMP_W'(addr);

  // Half-open interval test; a zero-size region has base == limit and
  // can never match, and the intervals never overlap.
  for (genvar i = 0; i < N_REGIONS; i++) begin : g_cmp
    logic ge_base;
    logic lt_limit;
    assign ge_base  = (a_ext >= CMP_W'(base[i]));
    assign lt_limit = (a_ext <  CMP_W'(limit[i]));
    assign hit[i]   = ge_base && lt_limit;
  end

  assign beyond = (a_ext >= CMP_W'(limit[N_REGIONS-1]));

endmodule

// File: rtl/flash_region_decoder.sv
module flash_region_decoder
  import flash_map_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int SIZE_W    = 20,
  parameter int SEQ_W     = 5,
  parameter int ADDR_W    = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      size_we,
  input  logic                                      seq_we,
  input  logic [flash_map_pkg::idx_width(N_REGIONS)-1:0] cfg_region,
  input  logic [SIZE_W-1:0]                         cfg_size,
  input  logic [SEQ_W-1:0]                          cfg_seq,
  input  logic                                      req_valid,
  input  logic [ADDR_W-1:0]                         req_addr,
  output logic                                      rsp_valid,
  output logic [N_REGIONS-1:0]                      rsp_sel,
  output logic [ADDR_W-1:0]                         rsp_offset,
  output logic [SEQ_W-1:0]                          rsp_seq,
  output logic                                      rsp_oor
);

  localparam int RIDX_W  = idx_width(N_REGIONS);
  localparam int BOUND_W = SIZE_W + RIDX_W + KB_SHIFT;
  localparam int CMP_W   = max_int(ADDR_W, BOUND_W);

  logic [N_REGIONS-1:0][SIZE_W-1:0]  size_q;
  logic [N_REGIONS-1:0][SEQ_W-1:0]   seq_q;
  logic [N_REGIONS-1:0][BOUND_W-1:0] base;
  logic [N_REGIONS-1:0][BOUND_W-1:0] limit;
  logic [N_REGIONS-1:0]              hit;
  logic                              beyond;
  logic [ADDR_W-1:0]                 off_d;
  logic [SEQ_W-1:0]                  seq_d;

  region_cfg_regs #(
    .N_REGIONS (N_REGIONS),
    .SIZE_W    (SIZE_W),
    .SEQ_W     (SEQ_W),
    .RIDX_W    (RIDX_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .size_we    (size_we),
    .seq_we     (seq_we),
    .cfg_region (cfg_region),
    .cfg_size   (cfg_size),
    .cfg_seq    (cfg_seq),
    .size_q     (size_q),
    .seq_q      (seq_q)
  );

  region_bounds #(
    .N_REGIONS (N_REGIONS),
    .SIZE_W    (SIZE_W),
    .BOUND_W   (BOUND_W)
  ) u_bounds (
    .size_q (size_q),
    .base   (base),
    .limit  (limit)
  );

  region_match #(
    .N_REGIONS (N_REGIONS),
    .ADDR_W    (ADDR_W),
    .BOUND_W   (BOUND_W),
    .CMP_W     (CMP_W)
  ) u_match (
    .addr   (req_addr),
    .base   (base),
    .limit  (limit),
    .hit    (hit),
    .beyond (beyond)
  );

  // AND-OR mux keyed by the one-hot hit vector; all zero when out of range.
  always_comb begin
    off_d = '0;
    seq_d = '0;
    for (int i = 0; i < N_REGIONS; i++) begin
      if (hit[i]) begin
        off_d = off_d | ADDR_W'(CMP_W'(req_addr) - CMP_W'(base[i]));
        seq_d = seq_d | seq_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_sel    <= '0;
      rsp_offset <= '0;
      rsp_seq    <= '0;
      rsp_oor    <= 1'b0;
    end else if (req_valid) begin
      rsp_sel    <= hit;
      rsp_offset <= off_d;
      rsp_seq    <= seq_d;
      rsp_oor    <= beyond;
    end
  end

endmodule

// File: rtl/flash_region_decoder_props.sv
module flash_region_decoder_props #(
  parameter int N_REGIONS = 4,
  parameter int SEQ_W     = 5,
  parameter int ADDR_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 rsp_valid,
  input logic [N_REGIONS-1:0] rsp_sel,
  input logic [ADDR_W-1:0]    rsp_offset,
  input logic [SEQ_W-1:0]     rsp_seq,
  input logic                 rsp_oor
);

  // R1: a reset cycle leaves the response side idle and cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_sel == '0 && !rsp_oor));

  // R3: a valid result either selects exactly one device or is out of range
  a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_oor ? (rsp_sel == '0) : ($countones(rsp_sel) == 1)));

  // R5: out of range carries no select, offset or sequence index
  a_r5_oor_empty: assert property (@(posedge clk) disable iff (rst)
    rsp_oor |-> (rsp_sel == '0 && rsp_offset == '0 && rsp_seq == '0));

  // R8: one result per lookup, one cycle later
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8: no lookup, no result, and the previous fields are held
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_sel) && $stable(rsp_offset)
                    && $stable(rsp_seq) && $stable(rsp_oor)));

endmodule

bind flash_region_decoder flash_region_decoder_props #(
  .N_REGIONS (N_REGIONS),
  .SEQ_W     (SEQ_W),
  .ADDR_W    (ADDR_W)
) u_props (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_sel    (rsp_sel),
  .rsp_offset (rsp_offset),
  .rsp_seq    (rsp_seq),
  .rsp_oor    (rsp_oor)
);

// File: tb/sim_flash_region_decoder.sv
`timescale 1ns/1ps
module sim_flash_region_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_we = 1'b0;
  logic        seq_we = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic [19:0] cfg_size = '0;
  logic [4:0]  cfg_seq = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_sel;
  logic [31:0] rsp_offset;
  logic [4:0]  rsp_seq;
  logic        rsp_oor;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench copy of the programmed layout
  logic [19:0] m_size [4];
  logic [4:0]  m_seq  [4];

  always #10 clk = ~clk;

  flash_region_decoder u0 (
    .clk(clk), .rst(rst), .size_we(size_we), .seq_we(seq_we),
    .cfg_region(cfg_region), .cfg_size(cfg_size), .cfg_seq(cfg_seq),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_offset(rsp_offset),
    .rsp_seq(rsp_seq), .rsp_oor(rsp_oor)
  );

  function automatic logic [31:0] region_start(input int r);
    logic [31:0] s = '0;
    for (int i = 0; i < r; i++) s = s + ({12'b0, m_size[i]} << 10);
    return s;
  endfunction

  function automatic void model(input logic [31:0] a, output logic [3:0] s,
                                output logic [31:0] off, output logic [4:0] q,
                                output logic o);
    logic [31:0] lo = '0;
    logic [31:0] hi;
    s = '0; off = '0; q = '0; o = 1'b1;
    for (int i = 0; i < 4; i++) begin
      hi = lo + ({12'b0, m_size[i]} << 10);
      if (o && a >= lo && a < hi) begin
        s = 4'b1 << i; off = a - lo; q = m_seq[i]; o = 1'b0;
      end
      lo = hi;
    end
  endfunction

  task automatic expect_rsp(input string tag, input logic [3:0] es,
                            input logic [31:0] eo, input logic [4:0] eq,
                            input logic eoor);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_sel !== es || rsp_offset !== eo ||
        rsp_seq !== eq || rsp_oor !== eoor) begin
      failures++;
      $display("FAIL %s: valid=%b sel=%b/%b off=%h/%h seq=%0d/%0d oor=%b/%b",
               tag, rsp_valid, rsp_sel, es, rsp_offset, eo, rsp_seq, eq,
               rsp_oor, eoor);
    end
  endtask

  // drive a lookup, sample one edge later
  task automatic lookup(input logic [31:0] a, input string tag);
    logic [3:0] es; logic [31:0] eo; logic [4:0] eq; logic eoor;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    model(a, es, eo, eq, eoor);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, es, eo, eq, eoor);
  endtask

  // one-edge write; returns just after the edge so a following lookup
  // lands in the very next cycle
  task automatic write_size(input int r, input logic [19:0] v);
    @(negedge clk);
    size_we = 1'b1; cfg_region = 2'(r); cfg_size = v;
    @(posedge clk); #1;
    size_we = 1'b0; cfg_size = $urandom;
    m_size[r] = v;
  endtask

  task automatic write_seq(input int r, input logic [4:0] v);
    @(negedge clk);
    seq_we = 1'b1; cfg_region = 2'(r); cfg_seq = v;
    @(posedge clk); #1;
    seq_we = 1'b0; cfg_seq = $urandom;
    m_seq[r] = v;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] es; logic [31:0] eo; logic [4:0] eq; logic eoor;
    logic [3:0] hs; logic [31:0] ho;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) begin m_size[i] = '0; m_seq[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: cleared outputs, then an out-of-range first lookup
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_sel !== 4'b0 || rsp_offset !== 32'b0 ||
        rsp_seq !== 5'b0 || rsp_oor !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: valid=%b sel=%b off=%h seq=%0d oor=%b exp all 0",
               rsp_valid, rsp_sel, rsp_offset, rsp_seq, rsp_oor);
    end
    lookup(32'h0, "R1 first lookup out of range");

    // R6: only region 2, full-space size
    write_size(2, 20'hFFFFF);
    lookup(32'h0, "R6 only region 2 low");
    lookup(32'h3FFF_FBFF, "R6 only region 2 top");
    lookup(32'h3FFF_FC00, "R5 end of only region");
    lookup(32'h1234_5678, "R6 only region 2 mid");

    // R2 R3 R4 R5 R7: sizes 1,2,0,3 KB with distinct sequence indices
    write_size(2, 20'd0);
    write_size(0, 20'd1);
    write_size(1, 20'd2);
    write_size(3, 20'd3);
    write_seq(0, 5'd7);
    write_seq(1, 5'd19);
    write_seq(2, 5'd31);
    write_seq(3, 5'd4);
    lookup(32'd0,    "R2 region 0 start");
    lookup(32'd1023, "R3 region 0 last byte");
    lookup(32'd1024, "R4 region 1 offset zero");
    lookup(32'd3071, "R4 region 1 last byte");
    lookup(32'd3072, "R6 zero region skipped, R7 seq");
    lookup(32'd6143, "R4 region 3 last byte");
    lookup(32'd6144, "R5 first out-of-range byte");
    lookup(32'hFFFF_FFFF, "R5 top address");

    // R10: sequence write leaves size alone, and vice versa
    write_seq(1, 5'd9);
    lookup(32'd3071, "R10 seq write keeps size");
    write_size(1, 20'd1);
    lookup(32'd2047, "R10 size write keeps seq");
    lookup(32'd2048, "R10 boundary moved");

    // R9: write immediately followed by a lookup
    write_size(0, 20'd4);
    lookup(32'd4095, "R9 new size used next cycle");

    // R9: lookup at the same edge as a write sees the old size
    @(negedge clk);
    model(32'd4096, es, eo, eq, eoor);
    size_we = 1'b1; cfg_region = 2'd0; cfg_size = 20'd8;
    req_valid = 1'b1; req_addr = 32'd4096;
    @(negedge clk);
    size_we = 1'b0; req_valid = 1'b0;
    m_size[0] = 20'd8;
    expect_rsp("R9 same-edge write uses old size", es, eo, eq, eoor);

    // R8: idle cycle holds fields, no valid
    hs = rsp_sel; ho = rsp_offset;
    req_addr = 32'd0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_sel !== hs || rsp_offset !== ho) begin
      failures++;
      $display("FAIL R8 idle: valid=%b/0 sel=%b/%b off=%h/%h",
               rsp_valid, rsp_sel, hs, rsp_offset, ho);
    end

    // random layouts and addresses, biased toward region edges
    for (int it = 0; it < 600; it++) begin
      logic [31:0] total;
      logic [31:0] a;
      int r;
      if (it % 30 == 0) begin
        for (int k = 0; k < 4; k++) begin
          case ($urandom % 5)
            0: write_size(k, 20'd0);
            1: write_size(k, 20'($urandom));
            default: write_size(k, 20'($urandom % 64 + 1));
          endcase
          write_seq(k, 5'($urandom));
        end
      end
      total = region_start(4);
      r = $urandom % 4;
      case ($urandom % 4)
        0: a = region_start(r);
        1: a = region_start(r) - 32'd1;
        2: a = total + ($urandom % 3) - 32'd1;
        default: a = (total == 0) ? $urandom : ($urandom % total);
      endcase
      lookup(a, "R2/R3/R4/R5/R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule